// File: doc/BRIEF.md
# Serial Register Port with Frame Checking

This block is a serial-peripheral target for the control registers of a power-management controller. A host lowers chip select and clocks in a 16-bit word. The word holds a command bit, a register address, a data byte and a parity bit. When chip select rises, the block judges the frame. A frame with the wrong clock count or bad parity is thrown away and an error flag is raised. If chip select stays low past a time limit, the frame is abandoned and a separate flag is raised. Any raised flag drives the interrupt request. Software clears each flag by writing a one to it.

SDO carries the answer to the previous frame: its command bit, six status bits, a data byte and parity. During a write, SDO instead repeats the bits just received on SDI. Registers in the protected bank accept writes only after a four-byte key has been written, in order, to the key register.

The SPI pins are sampled by the system clock through two-stage synchronizers, so SCLK must be several times slower than `clk`. The frame controller has four states:

- `ST_IDLE`: chip select is high. When it falls, the response word is loaded and the controller moves to `ST_SHIFT`.
- `ST_SHIFT`: bits are counted and shifted, and a timer runs. If chip select rises, the controller moves to `ST_EVAL`. If the timer reaches `CS_LIMIT`, it moves to `ST_OVERLONG`.
- `ST_OVERLONG`: the frame is dropped. When chip select rises, the controller returns to `ST_IDLE`.
- `ST_EVAL`: a one-cycle judgement that applies the write or the read, and sets any error flags. The controller then returns to `ST_IDLE`.

Top module: `spr_target`

## Requirements
- R1: A frame is 16 bits, MSB first, sampled on rising SCLK.
  - Bit 15 is the command (1 = write, 0 = read).
  - Bits 14:9 are the address and bits 8:1 are the data.
  - Bit 0 is parity, chosen so that the count of ones over all 16 bits is odd.
  - SDO changes only after falling SCLK edges.
- R2: The frame after an evaluated frame shifts out a response word, MSB first. The first bit is valid from chip-select fall, and each later bit follows a falling SCLK edge.
  - Bit 15 is the command bit of the evaluated frame, or 0 if that frame was rejected.
  - Bits 14:9 are status: bit 9 is the length flag, bit 10 the parity flag, bit 11 the duration flag, bit 12 the unlocked state, and bits 14:13 are zero.
  - Bits 8:1 are the register value for a valid read, otherwise 0.
  - Bit 0 is odd parity.
- R3: During a write frame, every SDO bit after the first is the SDI bit sampled at the previous rising edge.
- R4: A write frame with other than 16 rising SCLK edges is discarded, sets the length flag and raises the interrupt.
- R5: A read frame with other than 16 edges sets the length flag and raises the interrupt. Its response carries data 0 and command bit 0.
- R6: A 16-bit frame with wrong parity is discarded and sets the parity flag.
- R7: If chip select stays low for `CS_LIMIT` clock cycles, the frame is discarded and the duration flag is set.
- R8: The flag register at address 1Ch behaves as follows.
  - Bit 0 is the length flag, bit 1 the parity flag and bit 2 the duration flag.
  - Writing 1 to a bit clears it; writing 0 leaves it unchanged.
  - `irq` is high exactly while any flag is set.
- R9: The key register is at address 03h. The expected keys are ABh, EFh, 56h and 12h, in that order.
  - Each accepted key sets the next bit of the key-status register at 29h, bits 3:0.
  - A wrong value resets progress, except that ABh restarts the sequence at step one.
  - A write to any other register while the sequence is incomplete resets progress.
- R10: Registers 04h–07h always accept valid writes. Registers 10h–13h accept writes only while all four keys are valid; a locked write leaves their contents unchanged.
- R11: `sdo_oe` is low whenever `cs_n` is high, and high while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | SDO drive enable; pad is high-impedance when low |
| irq | output | 1 | Interrupt request, high while an error flag is set |

## Verification
Well-formed writes are mixed with reads of every register class, so that register behaviour is separated from the response word and from the write echo. Short writes, long reads, single-bit parity corruption and an over-held chip select each raise exactly one distinct flag; the reads that follow tell the discard from the flagging. Key sequences are tried complete, interrupted by another write, broken by a wrong byte and restarted with a repeated first key. Each of these is checked against the locked and unlocked behaviour of the protected bank.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SHIFT    = 2'd1,
        ST_OVERLONG = 2'd2,
        ST_EVAL     = 2'd3
    } spr_state_e;

    localparam int ERR_LEN = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_DUR = 2;
    localparam int ERR_W   = 3;
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                out_q  <= RST_VAL[g];
            end else begin
                meta_q <= d[g];
                out_q  <= meta_q;
            end
        end
        assign q[g] = out_q;
    end
endmodule

// File: rtl/spr_keyseq.sv
module spr_keyseq #(
    parameter int                         N_KEYS  = 4,
    parameter int                         DATA_W  = 8,
    parameter logic [N_KEYS*DATA_W-1:0]   KEY_SEQ = 32'hABEF_5612
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_KEYS-1:0] key_ok,
    output logic              unlocked
);
    localparam int PW = $clog2(N_KEYS + 1);

    logic [PW-1:0]     step_q, step_nx;
    logic [DATA_W-1:0] key_tab [N_KEYS];
    logic [DATA_W-1:0] expect_key;
    logic              at_end;

    for (genvar g = 0; g < N_KEYS; g++) begin : g_key
        assign key_tab[g] = KEY_SEQ[(N_KEYS-1-g)*DATA_W +: DATA_W];
        assign key_ok[g]  = step_q > PW'(g);
    end

    assign at_end   = (step_q == PW'(N_KEYS));
    assign unlocked = at_end;

    always_comb begin
        expect_key = key_tab[0];
        for (int i = 0; i < N_KEYS; i++) begin
            if (step_q == PW'(i)) expect_key = key_tab[i];
        end
    end

    always_comb begin
        step_nx = step_q;
        if (key_wr) begin
            if (!at_end && wdata == expect_key) step_nx = step_q + PW'(1);
            else if (wdata == key_tab[0])       step_nx = PW'(1);
            else                                step_nx = '0;
        end else if (other_wr && !at_end) begin
            step_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_nx;
    end
endmodule

// File: rtl/spr_regbank.sv
module spr_regbank #(
    parameter int          ADDR_W    = 6,
    parameter int          DATA_W    = 8,
    parameter int          N_GEN     = 4,
    parameter int          N_PROT    = 4,
    parameter int unsigned GEN_BASE  = 'h04,
    parameter int unsigned PROT_BASE = 'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     unlocked,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [N_GEN*DATA_W-1:0]  gen_flat,
    output logic [N_PROT*DATA_W-1:0] prot_flat
);
    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                         val_q <= '0;
            else if (wr_en && addr == ADDR_W'(GEN_BASE + g))    val_q <= wdata;
        end
        assign gen_flat[g*DATA_W +: DATA_W] = val_q;
    end

    for (genvar g = 0; g < N_PROT; g++) begin : g_prot
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else if (wr_en && unlocked && addr == ADDR_W'(PROT_BASE + g)) val_q <= wdata;
        end
        assign prot_flat[g*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/spr_target.sv
module spr_target
    import spr_pkg::*;
#(
    parameter int                       ADDR_W     = 6,
    parameter int                       DATA_W     = 8,
    parameter int                       CS_LIMIT   = 100_000,
    parameter int                       N_GEN      = 4,
    parameter int                       N_PROT     = 4,
    parameter int unsigned              GEN_BASE   = 'h04,
    parameter int unsigned              PROT_BASE  = 'h10,
    parameter int unsigned              KEY_ADDR   = 'h03,
    parameter int unsigned              ERR_ADDR   = 'h1C,
    parameter int unsigned              KSTAT_ADDR = 'h29,
    parameter int                       N_KEYS     = 4,
    parameter logic [N_KEYS*DATA_W-1:0] KEY_SEQ    = 32'hABEF_5612
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe,
    output logic irq
);
    localparam int FRAME_W = ADDR_W + DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int TMR_W   = $clog2(CS_LIMIT + 1);

    // synchronised pins: {cs_n, sclk, sdi}
    logic [2:0] pins_s;
    logic       cs_n_s, sclk_s, sdi_s, sclk_d;
    logic       sclk_rise, sclk_fall;

    spr_sync #(.WIDTH(3), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s} = pins_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    spr_state_e         state_q, state_nx;
    logic [FRAME_W-1:0] rx_sh, tx_sh, tx_word, resp_word;
    logic [CNT_W-1:0]   bit_cnt;
    logic [TMR_W-1:0]   cs_tmr;
    logic               is_wr, sdo_q, resp_pend, resp_ok;
    logic [ERR_W-1:0]   err_q, err_set, err_clr, err_nx;

    // decoded fields of the received word
    logic              f_cmd;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    assign f_cmd  = rx_sh[FRAME_W-1];
    assign f_addr = rx_sh[FRAME_W-2 -: ADDR_W];
    assign f_data = rx_sh[DATA_W:1];

    logic len_ok, par_ok, frame_ok, wr_go, tmr_hit;
    assign len_ok   = (bit_cnt == CNT_W'(FRAME_W));
    assign par_ok   = ^rx_sh;
    assign frame_ok = len_ok & par_ok;
    assign wr_go    = (state_q == ST_EVAL) & frame_ok & f_cmd;
    assign tmr_hit  = (cs_tmr == TMR_W'(CS_LIMIT - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (!cs_n_s) state_nx = ST_SHIFT;
            ST_SHIFT:    if (cs_n_s) state_nx = ST_EVAL;
                         else if (tmr_hit) state_nx = ST_OVERLONG;
            ST_OVERLONG: if (cs_n_s) state_nx = ST_IDLE;
            ST_EVAL:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // ---------------- key sequencer and register bank ----------------
    logic [N_KEYS-1:0]        key_ok;
    logic                     unlocked, key_wr, other_wr;
    logic [N_GEN*DATA_W-1:0]  gen_flat;
    logic [N_PROT*DATA_W-1:0] prot_flat;

    assign key_wr   = wr_go & (f_addr == ADDR_W'(KEY_ADDR));
    assign other_wr = wr_go & (f_addr != ADDR_W'(KEY_ADDR));

    spr_keyseq #(.N_KEYS(N_KEYS), .DATA_W(DATA_W), .KEY_SEQ(KEY_SEQ)) i_keyseq (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .other_wr(other_wr),
        .wdata(f_data), .key_ok(key_ok), .unlocked(unlocked)
    );

    spr_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GEN(N_GEN), .N_PROT(N_PROT),
        .GEN_BASE(GEN_BASE), .PROT_BASE(PROT_BASE)
    ) i_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .unlocked(unlocked),
        .addr(f_addr), .wdata(f_data), .gen_flat(gen_flat), .prot_flat(prot_flat)
    );

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_byte;
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < N_GEN; i++)
            if (f_addr == ADDR_W'(GEN_BASE + i)) rd_byte = gen_flat[i*DATA_W +: DATA_W];
        for (int i = 0; i < N_PROT; i++)
            if (f_addr == ADDR_W'(PROT_BASE + i)) rd_byte = prot_flat[i*DATA_W +: DATA_W];
        if (f_addr == ADDR_W'(ERR_ADDR))   rd_byte = DATA_W'(err_q);
        if (f_addr == ADDR_W'(KSTAT_ADDR)) rd_byte = DATA_W'(key_ok);
    end

    // ---------------- error flags ----------------
    always_comb begin
        err_set          = '0;
        err_set[ERR_LEN] = (state_q == ST_EVAL) & ~len_ok;
        err_set[ERR_PAR] = (state_q == ST_EVAL) & len_ok & ~par_ok;
        err_set[ERR_DUR] = (state_q == ST_SHIFT) & (state_nx == ST_OVERLONG);
        err_clr          = (wr_go && f_addr == ADDR_W'(ERR_ADDR)) ? f_data[ERR_W-1:0] : '0;
        err_nx           = (err_q & ~err_clr) | err_set;
    end

    // ---------------- response word ----------------
    always_comb begin
        resp_word    = {resp_ok & f_cmd,
                        ADDR_W'({unlocked, err_q}),
                        (resp_ok & ~f_cmd) ? rd_byte : {DATA_W{1'b0}},
                        1'b0};
        resp_word[0] = ~^resp_word[FRAME_W-1:1];
    end

    // ---------------- datapath outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_word   <= FRAME_W'(1);
            bit_cnt   <= '0;
            cs_tmr    <= '0;
            is_wr     <= 1'b0;
            sdo_q     <= 1'b0;
            resp_pend <= 1'b0;
            resp_ok   <= 1'b0;
            err_q     <= '0;
        end else begin
            sclk_d    <= sclk_s;
            err_q     <= err_nx;
            resp_pend <= (state_q == ST_EVAL) | ((state_q == ST_OVERLONG) & cs_n_s);
            resp_ok   <= (state_q == ST_EVAL) & frame_ok;
            if (resp_pend) tx_word <= resp_word;

            if (state_q == ST_IDLE && !cs_n_s) begin
                bit_cnt <= '0;
                cs_tmr  <= '0;
                is_wr   <= 1'b0;
                tx_sh   <= tx_word;
                sdo_q   <= tx_word[FRAME_W-1];
            end

            if (state_q == ST_SHIFT || state_q == ST_OVERLONG) begin
                if (state_q == ST_SHIFT) cs_tmr <= cs_tmr + TMR_W'(1);
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], sdi_s};
                    if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == '0) is_wr <= sdi_s;
                end
                if (sclk_fall) begin
                    tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                    sdo_q <= is_wr ? rx_sh[0] : tx_sh[FRAME_W-2];
                end
            end
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = ~cs_n;
    assign irq    = |err_q;
endmodule

// File: rtl/spr_target_chk.sv
module spr_target_chk
    import spr_pkg::*;
#(
    parameter int                GEN_W    = 32,
    parameter int                PROT_W   = 32,
    parameter int                CNT_W    = 5,
    parameter int                FRAME_W  = 16,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] KEY_LAST = 8'h12
) (
    input logic              clk,
    input logic              rst_n,
    input spr_state_e        state,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [GEN_W-1:0]  gen_flat,
    input logic [PROT_W-1:0] prot_flat,
    input logic              unlocked,
    input logic              key_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [2:0]        err_q,
    input logic              irq
);
    AST_GEN_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gen_flat) |-> ($past(state) == ST_EVAL && $past(bit_cnt) == CNT_W'(FRAME_W))); // R4

    AST_PROT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_flat) |-> $past(unlocked)); // R10

    AST_UNLOCK_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(key_wr) && $past(wdata) == KEY_LAST)); // R9

    AST_DUR_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[2]) |-> ($past(state) == ST_SHIFT && state == ST_OVERLONG)); // R7

    AST_PAR_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[1]) |-> ($past(state) == ST_EVAL && $past(bit_cnt) == CNT_W'(FRAME_W))); // R6

    AST_IRQ_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(state) == ST_EVAL)); // R8
endmodule

bind spr_target spr_target_chk #(
    .GEN_W(N_GEN*DATA_W), .PROT_W(N_PROT*DATA_W), .CNT_W(CNT_W),
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .KEY_LAST(KEY_SEQ[DATA_W-1:0])
) i_spr_target_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .bit_cnt(bit_cnt),
    .gen_flat(gen_flat), .prot_flat(prot_flat), .unlocked(unlocked),
    .key_wr(key_wr), .wdata(f_data), .err_q(err_q), .irq(irq)
);

// File: tb/test_spr_target.sv
module test_spr_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, irq;
    int   n_chk = 0, n_fail = 0;
    logic [15:0] cap;
    bit   done = 0;

    always #10 clk = ~clk;

    spr_target #(.CS_LIMIT(400)) i_spr_target (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic c, input logic [5:0] a, input logic [7:0] d);
        logic [15:0] w;
        w    = {c, a, d, 1'b0};
        w[0] = ~^w[15:1];
        return w;
    endfunction

    task automatic xfer(input logic [31:0] w, input int nb, input int hold);
        int idx = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 oe during frame", sdo_oe, 1);
        for (int i = nb - 1; i >= 0; i--) begin
            sdi = w[i];
            repeat (4) @(negedge clk);
            if (idx < 16) cap[15-idx] = sdo;
            idx++;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (hold) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R11 oe idle", sdo_oe, 0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        xfer({16'h0, mk(1'b1, a, d)}, 16, 0);
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] d, input logic [5:0] st);
        xfer({16'h0, mk(1'b0, a, 8'h00)}, 16, 0);
        xfer({16'h0, mk(1'b0, 6'h3F, 8'h00)}, 16, 0);
        chk({req, " R2 data"}, cap[8:1], d);
        chk({req, " R2 status"}, cap[14:9], st);
        chk({req, " R2 cmd"}, cap[15], 0);
        chk({req, " R1 parity"}, ^cap, 1);
    endtask

    task automatic t_reset;
        chk("R8 irq reset", irq, 0);
        chk("R11 oe reset", sdo_oe, 0);
    endtask

    task automatic t_rw_echo;
        logic [15:0] w;
        w = mk(1'b1, 6'h04, 8'h5A);
        xfer({16'h0, w}, 16, 0);
        chk("R3 echo", cap[14:0], w[15:1]);
        rd_chk("R10 gen", 6'h04, 8'h5A, 6'h00);
        wr(6'h07, 8'hC3);
        rd_chk("R10 gen7", 6'h07, 8'hC3, 6'h00);
        rd_chk("R2 unmapped", 6'h3E, 8'h00, 6'h00);
        wr(6'h05, 8'h0F);
        xfer({16'h0, mk(1'b0, 6'h3F, 8'h00)}, 16, 0);
        chk("R2 write cmd", cap[15], 1);
        chk("R2 write data", cap[8:1], 0);
    endtask

    task automatic t_len;
        xfer({16'h0, mk(1'b1, 6'h04, 8'h11)} >> 1, 15, 0);
        chk("R4 irq", irq, 1);
        rd_chk("R4 discard", 6'h04, 8'h5A, 6'h01);
        rd_chk("R8 flags", 6'h1C, 8'h01, 6'h01);
        wr(6'h1C, 8'h00);
        rd_chk("R8 write0", 6'h1C, 8'h01, 6'h01);
        wr(6'h1C, 8'h01);
        chk("R8 irq cleared", irq, 0);
        rd_chk("R8 cleared", 6'h1C, 8'h00, 6'h00);
        xfer({15'h0, mk(1'b0, 6'h04, 8'h00), 1'b1}, 17, 0);
        chk("R5 irq", irq, 1);
        xfer({16'h0, mk(1'b0, 6'h3F, 8'h00)}, 16, 0);
        chk("R5 data", cap[8:1], 0);
        chk("R5 cmd", cap[15], 0);
        chk("R5 status", cap[14:9], 6'h01);
        wr(6'h1C, 8'h01);
    endtask

    task automatic t_par;
        xfer({16'h0, mk(1'b1, 6'h04, 8'h77) ^ 16'h0001}, 16, 0);
        chk("R6 irq", irq, 1);
        rd_chk("R6 discard", 6'h04, 8'h5A, 6'h02);
        wr(6'h1C, 8'h02);
        chk("R6 cleared", irq, 0);
    endtask

    task automatic t_dur;
        xfer({16'h0, mk(1'b1, 6'h04, 8'h99)}, 16, 300);
        chk("R7 irq", irq, 1);
        rd_chk("R7 discard", 6'h04, 8'h5A, 6'h04);
        wr(6'h1C, 8'h04);
        chk("R7 cleared", irq, 0);
    endtask

    task automatic t_keys;
        wr(6'h10, 8'h3C);
        rd_chk("R10 locked", 6'h10, 8'h00, 6'h00);
        wr(6'h03, 8'hAB); wr(6'h03, 8'hEF); wr(6'h03, 8'h56);
        rd_chk("R9 three keys", 6'h29, 8'h07, 6'h00);
        wr(6'h04, 8'h21);
        rd_chk("R9 broken by other write", 6'h29, 8'h00, 6'h00);
        wr(6'h03, 8'hAB); wr(6'h03, 8'hEF); wr(6'h03, 8'h56); wr(6'h03, 8'h12);
        rd_chk("R9 unlocked", 6'h29, 8'h0F, 6'h08);
        wr(6'h10, 8'h3C);
        rd_chk("R10 unlocked write", 6'h10, 8'h3C, 6'h08);
        wr(6'h06, 8'h44);
        rd_chk("R9 stays unlocked", 6'h29, 8'h0F, 6'h08);
        wr(6'h03, 8'h00);
        rd_chk("R9 wrong key relock", 6'h29, 8'h00, 6'h00);
        wr(6'h10, 8'h55);
        rd_chk("R10 relocked", 6'h10, 8'h3C, 6'h00);
    endtask

    task automatic t_key_restart;
        wr(6'h03, 8'hAB); wr(6'h03, 8'hAB); wr(6'h03, 8'hEF);
        wr(6'h03, 8'h56); wr(6'h03, 8'h12);
        rd_chk("R9 restart", 6'h29, 8'h0F, 6'h08);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (R1) actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_rw_echo();
        t_len();
        t_par();
        t_dur();
        t_keys();
        t_key_restart();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule